// File: doc/BRIEF.md
# Cascaded ADC Serial Readout Controller

This block runs on the host side of a synchronous serial link to one current-input converter or to a daisy chain of them. It watches an active-low data-ready line. When that line falls, the block runs a gated data clock and shifts in every result held by the chain. Each device contributes four 20-bit channel words. The block rebuilds each word and presents it for one cycle, tagged with the device position and channel, and it raises a done pulse with the final word of the frame.

The block also owns the conversion-control output. A one-cycle request toggles that output. The data clock is held low for a guard interval on both sides of the toggle. A request that arrives during a readout is deferred until the bit in flight has finished its high phase. The readout then pauses, the toggle is issued, and shifting resumes with the next bit. No bit is lost.

The data clock is a divide of the local clock, so the link rate is set apart from the converter's own system clock. Outside a frame and outside the guard interval the data clock rests low.

Top module: `adc_chain_reader`

## Requirements
- R1: After reset, sclk, conv_out, word_valid and frame_done are all 0.
- R2: No data clock pulse is produced unless a high-to-low transition of drdy_n has been seen. While drdy_n stays high, sclk stays 0.
- R3: One frame gives exactly N_DEV*4*20 rising edges of sclk. After the last one, sclk returns low and stays low.
- R4: Each data clock period is CLK_DIV local cycles: CLK_DIV/2 (rounded down) low, then the remainder high. Consecutive pulses are separated by at least CLK_DIV/2 low cycles.
- R5: sdi is sampled on each rising edge of sclk. Every word is assembled most significant bit first, and word_data equals the 20 bits in arrival order.
- R6: The k-th word of a frame (k from 0) carries word_dev = k/4 (0 = device nearest the host) and word_ch = 3 - (k mod 4), where code 3 names channel 4, which arrives first.
- R7: word_valid is a one-cycle pulse per word. frame_done pulses in the same cycle as the last word of a frame and at no other time.
- R8: Each conv_req pulse toggles conv_out exactly once. sclk is low for at least CONV_GUARD cycles before the toggle and for CONV_GUARD cycles after it.
- R9: A conv_req during a readout lets the current bit finish its full high phase, pauses the clock low, and resumes after the toggle. No bit is dropped or repeated.
- R10: A single falling edge of drdy_n starts exactly one frame, even if drdy_n is then held low.
- R11: A conv_req while idle toggles conv_out without producing any data clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| drdy_n | input | 1 | Active-low data-ready from the chain (asynchronous, synchronized inside) |
| sdi | input | 1 | Serial data from the nearest device |
| conv_req | input | 1 | One-cycle request to toggle the conversion-control output |
| sclk | output | 1 | Gated data clock to the chain |
| conv_out | output | 1 | Conversion-control output |
| word_valid | output | 1 | Strobe for a completed word |
| word_data | output | WORD_W | Assembled word |
| word_dev | output | DEV_W | Device position of the word, 0 = nearest |
| word_ch | output | CH_W | Channel code, 3 = channel 4 |
| frame_done | output | 1 | Pulse with the last word of a frame |

## Verification
The hardest case to reach is a conversion request landing in the middle of a frame, especially one aligned with different phases of the data clock. Only then are bit preservation and the complete final high phase at stake. The bench issues conv_req at several cycle offsets after the data-ready edge, including offsets inside the high and low halves of a bit and right at frame end. A behavioural chain model shifts queued words out on each falling clock edge, so any lost or repeated bit shows up as a word mismatch. Odd divide ratios and a held-low data-ready line are also driven.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GUARD = 2'd2
  } rd_state_e;

  // device position of the k-th word in a frame (0 = nearest)
  function automatic int unsigned dev_of_word(input int unsigned k,
                                              input int unsigned ch_per_dev);
    return k / ch_per_dev;
  endfunction

  // channel code of the k-th word; highest channel is delivered first
  function automatic int unsigned ch_of_word(input int unsigned k,
                                             input int unsigned ch_per_dev);
    return ch_per_dev - 1 - (k % ch_per_dev);
  endfunction

  // rising edges of the data clock in one complete frame
  function automatic int unsigned frame_bits(input int unsigned n_dev,
                                             input int unsigned ch_per_dev,
                                             input int unsigned word_w);
    return n_dev * ch_per_dev * word_w;
  endfunction

endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= din_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;
endmodule

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise_evt,
  output logic bit_end
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [PW-1:0] ph;

  assign rise_evt = run && (ph == PW'(HALF - 1));
  assign bit_end  = run && (ph == PW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (!run) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else if (bit_end) begin
      ph   <= '0;
      sclk <= 1'b0;
    end else begin
      ph <= ph + 1'b1;
      if (rise_evt) sclk <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_rd_assembler.sv
module adc_rd_assembler
  import adc_rd_pkg::*;
#(
  parameter int WORD_W     = 20,
  parameter int N_DEV      = 2,
  parameter int CH_PER_DEV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              sdi,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [((N_DEV > 1) ? $clog2(N_DEV) : 1)-1:0] word_dev,
  output logic [((CH_PER_DEV > 1) ? $clog2(CH_PER_DEV) : 1)-1:0] word_ch,
  output logic              frame_done,
  output logic              all_sampled
);
  localparam int N_WORDS = N_DEV * CH_PER_DEV;
  localparam int BW      = $clog2(WORD_W);
  localparam int KW      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int DEV_W   = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int CH_W    = (CH_PER_DEV > 1) ? $clog2(CH_PER_DEV) : 1;

  logic [WORD_W-2:0] sh;
  logic [BW-1:0]     bit_i;
  logic [KW-1:0]     word_i;
  logic              word_end, last_word;

  assign word_end  = sample && (bit_i == BW'(WORD_W - 1));
  assign last_word = word_end && (word_i == KW'(N_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      bit_i       <= '0;
      word_i      <= '0;
      all_sampled <= 1'b0;
      word_valid  <= 1'b0;
      frame_done  <= 1'b0;
      word_data   <= '0;
      word_dev    <= '0;
      word_ch     <= '0;
    end else begin
      word_valid <= 1'b0;
      frame_done <= 1'b0;
      if (clear) begin
        bit_i       <= '0;
        word_i      <= '0;
        all_sampled <= 1'b0;
      end else if (sample) begin
        sh <= {sh[WORD_W-3:0], sdi};
        if (word_end) begin
          bit_i      <= '0;
          word_valid <= 1'b1;
          word_data  <= {sh, sdi};
          word_dev   <= DEV_W'(dev_of_word(int'(word_i), CH_PER_DEV));
          word_ch    <= CH_W'(ch_of_word(int'(word_i), CH_PER_DEV));
          if (last_word) begin
            frame_done  <= 1'b1;
            all_sampled <= 1'b1;
            word_i      <= '0;
          end else begin
            word_i <= word_i + 1'b1;
          end
        end else begin
          bit_i <= bit_i + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
  import adc_rd_pkg::*;
#(
  parameter int N_DEV      = 2,
  parameter int WORD_W     = 20,
  parameter int CH_PER_DEV = 4,
  parameter int CLK_DIV    = 4,
  parameter int CONV_GUARD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drdy_n,
  input  logic              sdi,
  input  logic              conv_req,
  output logic              sclk,
  output logic              conv_out,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [((N_DEV > 1) ? $clog2(N_DEV) : 1)-1:0] word_dev,
  output logic [((CH_PER_DEV > 1) ? $clog2(CH_PER_DEV) : 1)-1:0] word_ch,
  output logic              frame_done
);
  localparam int GC_W = (2 * CONV_GUARD > 2) ? $clog2(2 * CONV_GUARD) : 1;

  rd_state_e      st;
  logic [GC_W-1:0] gcnt;
  logic drdy_fall, drdy_pend, conv_pend, resume;
  logic shifting, in_guard, sample_evt, bit_end, all_sampled;
  logic frame_start, guard_mid, guard_last, enter_guard;

  // named internal events, used by the bound checker
  assign shifting    = (st == ST_SHIFT);
  assign in_guard    = (st == ST_GUARD);
  assign frame_start = (st == ST_IDLE) && drdy_pend && !conv_pend;
  assign guard_mid   = in_guard && (gcnt == GC_W'(CONV_GUARD - 1));
  assign guard_last  = in_guard && (gcnt == GC_W'(2 * CONV_GUARD - 1));
  assign enter_guard = ((st == ST_IDLE) && conv_pend) ||
                       (shifting && bit_end && !all_sampled && conv_pend);

  adc_rd_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n (drdy_n),
    .fall  (drdy_fall)
  );

  adc_rd_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (shifting),
    .sclk     (sclk),
    .rise_evt (sample_evt),
    .bit_end  (bit_end)
  );

  adc_rd_assembler #(
    .WORD_W     (WORD_W),
    .N_DEV      (N_DEV),
    .CH_PER_DEV (CH_PER_DEV)
  ) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (frame_start),
    .sample      (sample_evt),
    .sdi         (sdi),
    .word_valid  (word_valid),
    .word_data   (word_data),
    .word_dev    (word_dev),
    .word_ch     (word_ch),
    .frame_done  (frame_done),
    .all_sampled (all_sampled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      gcnt      <= '0;
      drdy_pend <= 1'b0;
      conv_pend <= 1'b0;
      resume    <= 1'b0;
      conv_out  <= 1'b0;
    end else begin
      if (drdy_fall)        drdy_pend <= 1'b1;
      else if (frame_start) drdy_pend <= 1'b0;

      if (conv_req)         conv_pend <= 1'b1;
      else if (enter_guard) conv_pend <= 1'b0;

      unique case (st)
        ST_IDLE: begin
          if (conv_pend) begin
            st     <= ST_GUARD;
            gcnt   <= '0;
            resume <= 1'b0;
          end else if (drdy_pend) begin
            st <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (bit_end) begin
            if (all_sampled) begin
              st <= ST_IDLE;
            end else if (conv_pend) begin
              st     <= ST_GUARD;
              gcnt   <= '0;
              resume <= 1'b1;
            end
          end
        end
        ST_GUARD: begin
          gcnt <= gcnt + 1'b1;
          if (guard_mid) conv_out <= ~conv_out;
          if (guard_last) begin
            gcnt <= '0;
            st   <= resume ? ST_SHIFT : ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic conv_out,
  input logic word_valid,
  input logic frame_done,
  input logic shifting,
  input logic in_guard,
  input logic sample_evt
);
  // R3: data clock rests low outside the shifting state
  assert_idle_clock_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> !sclk);

  // R8: no data clock pulse inside the conversion guard
  assert_guard_clock_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_guard |-> !sclk);

  // R8: conversion-control only changes deep inside a guard interval
  assert_conv_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_out != $past(conv_out)) |-> (in_guard && $past(in_guard) && !$past(sclk)));

  // R7: one-cycle word strobe
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R7: frame end only with a word
  assert_done_with_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> word_valid);

  // R5: sampling coincides with the data clock rising
  assert_sample_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> $rose(sclk));
endmodule

bind adc_chain_reader adc_rd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk       (sclk),
  .conv_out   (conv_out),
  .word_valid (word_valid),
  .frame_done (frame_done),
  .shifting   (shifting),
  .in_guard   (in_guard),
  .sample_evt (sample_evt)
);

// File: tb/adc_chain_reader_bench.sv
`timescale 1ns/1ps
module adc_chain_reader_bench;
  localparam int NDEV  = 2;
  localparam int WW    = 20;
  localparam int DIV   = 5;
  localparam int GRD   = 4;
  localparam int NW    = NDEV * 4;
  localparam int LOWC  = DIV / 2;
  localparam int HIGHC = DIV - LOWC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drdy_n = 1'b1;
  logic sdi = 1'b0;
  logic conv_req = 1'b0;
  logic sclk, conv_out, word_valid, frame_done;
  logic [WW-1:0] word_data;
  logic [0:0] word_dev;
  logic [1:0] word_ch;

  always #4 clk = ~clk;

  adc_chain_reader #(.N_DEV(NDEV), .WORD_W(WW), .CH_PER_DEV(4),
                     .CLK_DIV(DIV), .CONV_GUARD(GRD)) u_adc_chain_reader (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .sdi(sdi), .conv_req(conv_req),
    .sclk(sclk), .conv_out(conv_out), .word_valid(word_valid),
    .word_data(word_data), .word_dev(word_dev), .word_ch(word_ch),
    .frame_done(frame_done));

  int checks = 0, failures = 0;
  int rises = 0, done_cnt = 0, toggles = 0, conv_reqs = 0, cycles = 0;
  int exp_k = 0, low_run = 1000, high_run = 0, post_conv = 0;
  bit stick = 1'b0, prev_sclk = 1'b0, prev_conv = 1'b0, finished = 1'b0;
  bit bitq[$];
  logic [WW-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural chain: next bit presented on each falling data clock
  always @(negedge sclk) begin
    if (bitq.size() > 0) void'(bitq.pop_front());
    sdi = (bitq.size() > 0) ? bitq[0] : 1'b0;
  end
  always @(posedge sclk) begin
    rises++;
    if (!stick) drdy_n = 1'b1;
  end

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_sclk && sclk) begin
        chk(low_run >= LOWC, "R4", "low phase before rise", low_run, LOWC);
        low_run = 0;
      end
      if (prev_sclk && !sclk) begin
        chk(high_run == HIGHC, "R4/R9", "high phase width", high_run, HIGHC);
        high_run = 0;
      end
      if (sclk) high_run++; else low_run++;
      if (post_conv > 0) begin
        chk(!sclk, "R8", "sclk low after toggle", sclk, 0);
        post_conv--;
      end
      if (conv_out != prev_conv) begin
        toggles++;
        chk(low_run >= GRD && !sclk, "R8", "low run before toggle", low_run, GRD);
        post_conv = GRD;
      end
      if (word_valid) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5", "unexpected word", word_data, 0);
        end else begin
          logic [WW-1:0] e;
          e = expq.pop_front();
          chk(word_data == e, "R5", "word data", word_data, e);
          chk(word_dev == exp_k / 4, "R6", "device index", word_dev, exp_k / 4);
          chk(word_ch == 3 - (exp_k % 4), "R6", "channel code", word_ch, 3 - (exp_k % 4));
          chk(frame_done == (exp_k == NW - 1), "R7", "done with last word",
              frame_done, exp_k == NW - 1);
          exp_k = (exp_k + 1) % NW;
        end
      end else begin
        chk(!frame_done, "R7", "done without word", frame_done, 0);
      end
      if (frame_done) done_cnt++;
      prev_sclk = sclk;
      prev_conv = conv_out;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [WW-1:0] pattern(input int mode, input int k);
    case (mode)
      1: return '1;
      2: return '0;
      3: return (k % 2) ? 20'h55555 : 20'hAAAAA;
      4: return WW'(k * 20'h1_1111 + 20'h8_0001);
      default: return WW'($urandom);
    endcase
  endfunction

  task automatic load(input int mode, input bit hold_low);
    drdy_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int k = 0; k < NW; k++) begin
      logic [WW-1:0] w;
      w = pattern(mode, k);
      expq.push_back(w);
      for (int b = WW - 1; b >= 0; b--) bitq.push_back(w[b]);
    end
    sdi = bitq[0];
    stick = hold_low;
    drdy_n = 1'b0;
  endtask

  task automatic run_frame(input int mode, input int d1, input int d2,
                           input bit hold_low, input string req);
    int r0, dn0, cyc;
    r0 = rises; dn0 = done_cnt; cyc = 0;
    load(mode, hold_low);
    while (done_cnt == dn0 && cyc < 6000) begin
      @(negedge clk);
      conv_req = (cyc == d1 || cyc == d2);
      if (conv_req) conv_reqs++;
      cyc++;
    end
    @(negedge clk);
    conv_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(done_cnt == dn0 + 1, req, "frames completed", done_cnt - dn0, 1);
    chk(rises - r0 == NW * WW, "R3", "rising edges per frame", rises - r0, NW * WW);
    chk(expq.size() == 0, "R5", "words left unread", expq.size(), 0);
    chk(!sclk, "R3", "sclk parked low", sclk, 0);
  endtask

  initial begin
    int r0, t0;
    repeat (5) @(negedge clk);
    chk(!sclk && !conv_out && !word_valid && !frame_done, "R1", "reset outputs",
        {sclk, conv_out, word_valid, frame_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sclk && !conv_out && !word_valid && !frame_done, "R1", "post-reset outputs",
        {sclk, conv_out, word_valid, frame_done}, 0);

    // R2: data-ready held high
    repeat (100) @(negedge clk);
    chk(rises == 0, "R2", "no clock without ready", rises, 0);

    // R5/R6: several data patterns
    run_frame(0, -1, -1, 1'b0, "R5");
    run_frame(1, -1, -1, 1'b0, "R5");
    run_frame(2, -1, -1, 1'b0, "R5");
    run_frame(3, -1, -1, 1'b0, "R6");
    run_frame(4, -1, -1, 1'b0, "R6");

    // R10: ready held low after the frame
    run_frame(0, -1, -1, 1'b1, "R10");
    r0 = rises;
    repeat (400) @(negedge clk);
    chk(rises == r0, "R10", "no second frame", rises - r0, 0);
    stick = 1'b0;
    drdy_n = 1'b1;
    repeat (10) @(negedge clk);

    // R11: conversion toggle while idle
    t0 = toggles; r0 = rises;
    @(negedge clk); conv_req = 1'b1; conv_reqs++;
    @(negedge clk); conv_req = 1'b0;
    repeat (3 * GRD + 10) @(negedge clk);
    chk(toggles == t0 + 1, "R11", "idle toggle", toggles - t0, 1);
    chk(rises == r0, "R11", "no clock on idle toggle", rises - r0, 0);

    // R9: conversion requests during readouts at varied phases
    run_frame(0, 60, -1, 1'b0, "R9");
    run_frame(3, 61, 400, 1'b0, "R9");
    run_frame(4, 62, 503, 1'b0, "R9");
    run_frame(0, 63, 264, 1'b0, "R9");
    run_frame(1, 10, 790, 1'b0, "R9");
    run_frame(0, 7, 815, 1'b0, "R9");

    repeat (3 * GRD + 20) @(negedge clk);
    chk(toggles == conv_reqs, "R8", "one toggle per request", toggles, conv_reqs);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule